// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block produces the reset for a small microcontroller core. It has two reset sources. The first is a low-voltage flag from an analog supply comparator. The comparator is outside this block and sets its trip point; the supply band that counts as low starts at about 0.9 V and ends at a threshold of 2.2 V or 3.0 V. The second source is an active-low external reset pin. Both inputs are asynchronous, so each is brought into the clock domain through two flip-flops. A static enable input switches the low-voltage source on or off.

The low-voltage flag has to stay high for one millisecond before it counts, so short dips on the supply are ignored. The millisecond is given as a parameter, in clock cycles. A qualified low-voltage request and the external pin request are ORed together. When the combined request goes away, reset is still held for a fixed start-up time of system clocks so that the oscillator can settle. If a request comes back during that time, the start-up count begins again from zero.

Two sticky cause bits record which source was active at the start of the most recent reset. Software clears both bits with a one-cycle strobe.

Top module: `brownout_reset_seq`

## Requirements
- R1: While `por_n` is low, `core_rst` is 1 and both cause bits are 0. After `por_n` rises with no source active, `core_rst` falls at the STARTUP_CYCLES-th rising clock edge.
- R2: Driving `ext_rst_n` low sets `core_rst` to 1 from the third rising edge. After the pin returns high, `core_rst` falls at rising edge STARTUP_CYCLES+2.
- R3: A low-voltage flag that stays high for fewer than CLK_PER_MS clock cycles never asserts `core_rst`.
- R4: A low-voltage flag that stays high for CLK_PER_MS cycles or more sets `core_rst` to 1 at rising edge CLK_PER_MS+3 after the flag rises. After the flag falls, `core_rst` falls at rising edge STARTUP_CYCLES+3.
- R5: The two sources are ORed. Reset is held while either one is active, and the start-up time is counted from the moment the last active source clears.
- R6: While `lv_enable` is 0, the low-voltage flag has no effect on `core_rst` or on the cause bits.
- R7: If any source reasserts during the start-up hold, the hold restarts and runs its full length after that source clears.
- R8: On the first cycle of a new reset request, `cause_lv` takes the qualified low-voltage state and `cause_ext` takes the synchronised pin state. Both bits keep their values until the next request onset or until they are cleared.
- R9: A high `status_clr` in a cycle with no request onset clears both cause bits at the next edge.
- R10: Any cycle in which the synchronised low-voltage flag is low restarts the qualification time. Two sub-threshold pulses separated by a one-cycle gap therefore do not cause a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| lv_flag_async | input | 1 | Low-voltage flag from the supply comparator, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| lv_enable | input | 1 | Static enable for the low-voltage source |
| status_clr | input | 1 | Software strobe that clears both cause bits |
| core_rst | output | 1 | Chip reset to the core, active high, registered |
| cause_lv | output | 1 | The most recent reset began with a qualified low-voltage request |
| cause_ext | output | 1 | The most recent reset began with the external pin active |

## Verification
The bound checker checks these rules on every cycle:
- An active request always holds reset at the next edge.
- Reset is released only after a cycle with no request.
- A qualified low-voltage request never appears while the function is disabled, or without the synchronised flag in the previous cycle.
- Each cause bit rises only when its source was active.
- The clear strobe empties both cause bits.

Only the directed scenarios can show the timing and filtering behaviour. This covers the exact release edge after each source clears, the boundary of one cycle short of qualification, dips separated by a one-cycle gap, the hold restart after a second pulse, and release timing when the two sources overlap.

// File: rtl/brownout_reset_seq.sv
module brownout_reset_seq #(
  parameter int CLK_PER_MS     = 4000,
  parameter int STARTUP_CYCLES = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic lv_flag_async,
  input  logic ext_rst_n,
  input  logic lv_enable,
  input  logic status_clr,
  output logic core_rst,
  output logic cause_lv,
  output logic cause_ext
);

  localparam int QW = $clog2(CLK_PER_MS + 1);
  localparam int HW = $clog2(STARTUP_CYCLES);
  localparam logic [QW-1:0] QUAL_MAX  = QW'(CLK_PER_MS);
  localparam logic [HW-1:0] HOLD_LAST = HW'(STARTUP_CYCLES - 1);

  logic [1:0]    lv_sync, ext_sync;
  logic [QW-1:0] qual_cnt;
  logic [HW-1:0] hold_cnt;
  logic          req_d;
  logic          lv_s, ext_s, lv_qual, rst_req, onset;

  assign lv_s    = lv_sync[1];
  assign ext_s   = ext_sync[1];
  assign lv_qual = lv_enable && (qual_cnt == QUAL_MAX);
  assign rst_req = lv_qual || ext_s;
  assign onset   = rst_req && !req_d;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lv_sync  <= '0;
      ext_sync <= '0;
    end else begin
      lv_sync  <= {lv_sync[0], lv_flag_async};
      ext_sync <= {ext_sync[0], ~ext_rst_n};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  qual_cnt <= '0;
    else if (!lv_enable || !lv_s) qual_cnt <= '0;
    else if (qual_cnt != QUAL_MAX) qual_cnt <= qual_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_cnt <= '0;
      core_rst <= 1'b1;
    end else if (rst_req) begin
      hold_cnt <= '0;
      core_rst <= 1'b1;
    end else if (core_rst) begin
      if (hold_cnt == HOLD_LAST) core_rst <= 1'b0;
      else                       hold_cnt <= hold_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      req_d     <= 1'b0;
      cause_lv  <= 1'b0;
      cause_ext <= 1'b0;
    end else begin
      req_d <= rst_req;
      if (onset) begin
        cause_lv  <= lv_qual;
        cause_ext <= ext_s;
      end else if (status_clr) begin
        cause_lv  <= 1'b0;
        cause_ext <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/brownout_reset_seq_chk.sv
module brownout_reset_seq_chk (
  input logic clk,
  input logic por_n,
  input logic core_rst,
  input logic rst_req,
  input logic lv_s,
  input logic lv_qual,
  input logic lv_enable,
  input logic ext_s,
  input logic status_clr,
  input logic cause_lv,
  input logic cause_ext
);

  p_req_holds_rst_r5: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> core_rst);

  p_release_after_quiet_r7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst) |-> !$past(rst_req));

  p_disabled_no_qual_r6: assert property (@(posedge clk) disable iff (!por_n)
    !lv_enable |-> !lv_qual);

  p_qual_after_flag_r4: assert property (@(posedge clk) disable iff (!por_n)
    lv_qual |-> $past(lv_s));

  p_lv_cause_src_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cause_lv) |-> $past(lv_qual));

  p_ext_cause_src_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cause_ext) |-> $past(ext_s));

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!por_n)
    (status_clr && !rst_req) |=> (!cause_lv && !cause_ext));

endmodule

bind brownout_reset_seq brownout_reset_seq_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .core_rst   (core_rst),
  .rst_req    (rst_req),
  .lv_s       (lv_s),
  .lv_qual    (lv_qual),
  .lv_enable  (lv_enable),
  .ext_s      (ext_s),
  .status_clr (status_clr),
  .cause_lv   (cause_lv),
  .cause_ext  (cause_ext)
);

// File: tb/test_brownout_reset_seq.sv
`timescale 1ns/1ps
module test_brownout_reset_seq;
  localparam int QP = 40;
  localparam int HP = 1024;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic lv_flag_async = 1'b0;
  logic ext_rst_n = 1'b1;
  logic lv_enable = 1'b1;
  logic status_clr = 1'b0;
  logic core_rst, cause_lv, cause_ext;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brownout_reset_seq #(.CLK_PER_MS(QP), .STARTUP_CYCLES(HP)) i_brownout_reset_seq (
    .clk(clk), .por_n(por_n), .lv_flag_async(lv_flag_async), .ext_rst_n(ext_rst_n),
    .lv_enable(lv_enable), .status_clr(status_clr),
    .core_rst(core_rst), .cause_lv(cause_lv), .cause_ext(cause_ext));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_rst(input logic v, input string req);
    check(core_rst === v, req, int'(core_rst), int'(v));
  endtask

  task automatic expect_causes(input logic lv, input logic ex, input string req);
    check(cause_lv === lv && cause_ext === ex, req, int'({cause_lv, cause_ext}), int'({lv, ex}));
  endtask

  task automatic watch_no_rst(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (core_rst !== 1'b0) seen = 1'b1;
    end
    check(!seen, req, int'(seen), 0);
  endtask

  task automatic clear_causes();
    status_clr = 1'b1;
    step(1);
    status_clr = 1'b0;
  endtask

  task automatic t_power_up();
    step(3);
    expect_rst(1'b1, "R1 reset during por");
    expect_causes(1'b0, 1'b0, "R1 causes at por");
    por_n = 1'b1;
    step(HP - 1);
    expect_rst(1'b1, "R1 hold before release");
    step(1);
    expect_rst(1'b0, "R1 release edge");
  endtask

  task automatic t_ext_pin();
    ext_rst_n = 1'b0;
    step(2);
    expect_rst(1'b0, "R2 not yet asserted");
    step(1);
    expect_rst(1'b1, "R2 asserted");
    expect_causes(1'b0, 1'b1, "R8 ext cause");
    step(20);
    ext_rst_n = 1'b1;
    step(2 + HP - 1);
    expect_rst(1'b1, "R2 hold before release");
    step(1);
    expect_rst(1'b0, "R2 release edge");
    expect_causes(1'b0, 1'b1, "R8 cause kept");
  endtask

  task automatic t_clear();
    clear_causes();
    expect_causes(1'b0, 1'b0, "R9 clear");
  endtask

  task automatic t_lv_short();
    lv_flag_async = 1'b1;
    step(QP - 1);
    lv_flag_async = 1'b0;
    watch_no_rst(60, "R3 short dip ignored");
    expect_causes(1'b0, 1'b0, "R3 no cause");
  endtask

  task automatic t_lv_gap();
    lv_flag_async = 1'b1;
    step(QP - 1);
    lv_flag_async = 1'b0;
    step(1);
    lv_flag_async = 1'b1;
    step(QP - 1);
    lv_flag_async = 1'b0;
    watch_no_rst(60, "R10 gap restarts filter");
  endtask

  task automatic t_lv_long();
    lv_flag_async = 1'b1;
    step(QP + 2);
    expect_rst(1'b0, "R4 not yet asserted");
    step(1);
    expect_rst(1'b1, "R4 asserted");
    expect_causes(1'b1, 1'b0, "R8 lv cause");
    step(10);
    lv_flag_async = 1'b0;
    step(3 + HP - 1);
    expect_rst(1'b1, "R4 hold before release");
    step(1);
    expect_rst(1'b0, "R4 release edge");
    clear_causes();
  endtask

  task automatic t_disabled();
    lv_enable = 1'b0;
    step(2);
    lv_flag_async = 1'b1;
    watch_no_rst(QP + 30, "R6 disabled flag ignored");
    expect_causes(1'b0, 1'b0, "R6 no cause");
    lv_flag_async = 1'b0;
    step(5);
    lv_enable = 1'b1;
    step(5);
    expect_rst(1'b0, "R6 still idle");
  endtask

  task automatic t_or();
    ext_rst_n = 1'b0;
    step(5);
    lv_flag_async = 1'b1;
    step(QP + 10);
    lv_flag_async = 1'b0;
    step(10);
    expect_rst(1'b1, "R5 ext still holds");
    expect_causes(1'b0, 1'b1, "R8 onset from ext only");
    ext_rst_n = 1'b1;
    step(2 + HP - 1);
    expect_rst(1'b1, "R5 hold before release");
    step(1);
    expect_rst(1'b0, "R5 release after last source");
    clear_causes();
  endtask

  task automatic t_restart();
    ext_rst_n = 1'b0;
    step(5);
    ext_rst_n = 1'b1;
    step(2 + 500);
    expect_rst(1'b1, "R7 mid hold");
    ext_rst_n = 1'b0;
    step(3);
    ext_rst_n = 1'b1;
    step(2 + HP - 1);
    expect_rst(1'b1, "R7 full hold after restart");
    step(1);
    expect_rst(1'b0, "R7 release edge");
  endtask

  initial begin
    t_power_up();
    t_ext_pin();
    t_clear();
    t_lv_short();
    t_lv_gap();
    t_lv_long();
    t_disabled();
    t_or();
    t_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule